// File: doc/BRIEF.md
# Synchronous FIFO Controller with Selectable Aspect Ratio and Programmable Flags

This block turns a single-clock RAM into a first-in first-out queue. The RAM is organised as a fixed number of base words of a fixed base width. A mode setting trades width for depth: each step up in mode halves the data width and doubles the depth. With the default sizing, mode 0 gives 128 entries of 36 bits and mode 5 gives 4096 entries of 1 bit. Narrow entries are packed as lanes inside the base words.

The controller owns the read and write address counters and an occupancy counter. It refuses operations that would overflow or underflow the queue. It drives empty, full, almost-empty and almost-full flags, and the two almost thresholds can be changed while the queue runs. A user writes by raising the write enable with data and reads by raising the read enable. Read data appears on the clock edge that accepts the read.

Top module: `sync_fifo_ctrl`

## Requirements
- R1: While reset is high and at the first edge after it, the outputs are empty=1, full=0, almost_empty=1, almost_full=0, level=0 and rd_data=0.
- R2: The mode is captured only on edges where reset is high. Mode m gives depth BASE_DEPTH<<m and width BASE_WIDTH>>m. Modes above MODES-1 act as mode MODES-1. Write data bits at or above the width are dropped, and rd_data bits at or above the width read as zero.
- R3: Accepted reads return the accepted writes in the order they were written.
- R4: A write while level equals the depth is ignored. Nothing is stored and level does not rise.
- R5: A read while level is zero is ignored. rd_data and level are unchanged.
- R6: A read and a write together, with 0 < level < depth, are both accepted and leave level unchanged.
- R7: empty is 1 exactly when level is 0. full is 1 exactly when level equals the depth.
- R8: almost_empty is 1 exactly when level <= ae_thresh.
- R9: almost_full is 1 exactly when level + af_thresh >= depth.
- R10: All flags and level are registered. After each edge they reflect the occupancy that results from that edge's operations, judged against the thresholds present at that edge.
- R11: rd_data changes only on an edge that accepts a read, and it holds its value otherwise.
- R12: The write and read addresses wrap from depth-1 to 0, so the queue can cycle through the storage many times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the mode is captured while it is high |
| cfg_mode | input | 3 | Aspect-ratio mode: depth BASE_DEPTH<<m, width BASE_WIDTH>>m |
| ae_thresh | input | 13 | Almost-empty threshold, as an entry count |
| af_thresh | input | 13 | Almost-full threshold, as free entries below the depth |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Write data; only the low width bits are used |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Read data, registered; upper bits are zero |
| empty | output | 1 | Queue holds no entries |
| full | output | 1 | Queue holds depth entries |
| almost_empty | output | 1 | level <= ae_thresh |
| almost_full | output | 1 | level + af_thresh >= depth |
| level | output | 13 | Current number of stored entries |

## Verification
The bench uses the default sizing of 128 base words of 36 bits with six modes. It runs modes 0, 2 and 5, plus the out-of-range code 7. Mode 0 tests whole-word storage with the full 36-bit data path. Mode 2 packs four 9-bit lanes into each word. Mode 5 packs thirty-two 1-bit lanes into each word and reaches the maximum depth of 4096, so the level counter uses all its bits. Each mode is filled and drained past both ends, run with simultaneous reads and writes, and driven with random traffic while the thresholds change. Among the thresholds used are zero and a value above the depth, which keeps almost_full high all the time. One run changes the mode without a reset, and the depth must stay as it was.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    typedef logic [2:0] mode_t;

    // Limit a requested aspect mode to the largest one implemented.
    function automatic mode_t clamp_mode(input mode_t req, input int unsigned top);
        return (int'(req) > int'(top)) ? mode_t'(top) : req;
    endfunction

endpackage

// File: rtl/sfifo_ptr_ctrl.sv
module sfifo_ptr_ctrl
    import sfifo_pkg::*;
#(
    parameter int BASE_DEPTH = 128,
    parameter int MODES      = 6,
    localparam int BAW = $clog2(BASE_DEPTH),
    localparam int AW  = BAW + MODES - 1,
    localparam int LW  = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] depth,
    input  logic          wr_req,
    input  logic          rd_req,
    output logic          wr_go,
    output logic          rd_go,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [LW-1:0] level,
    output logic [LW-1:0] level_nx
);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [LW-1:0] lvl;
    } pst_t;

    pst_t st_q, st_d;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p, input logic [LW-1:0] dep);
        return ({1'b0, p} == dep - 1'b1) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d  = st_q;
        wr_go = wr_req && (st_q.lvl != depth);
        rd_go = rd_req && (st_q.lvl != '0);
        if (wr_go) st_d.wp = bump(st_q.wp, depth);
        if (rd_go) st_d.rp = bump(st_q.rp, depth);
        unique case ({wr_go, rd_go})
            2'b10:   st_d.lvl = st_q.lvl + 1'b1;
            2'b01:   st_d.lvl = st_q.lvl - 1'b1;
            default: st_d.lvl = st_q.lvl;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign wr_ptr   = st_q.wp;
    assign rd_ptr   = st_q.rp;
    assign level    = st_q.lvl;
    assign level_nx = st_d.lvl;

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        level <= depth);
    a_r4_full_write_blocked: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !rd_req && level == depth) |=> $stable(level));
    a_r5_empty_read_blocked: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !wr_req && level == '0) |=> (level == '0));
    a_r6_level_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_req && rd_req && level != '0 && level != depth) |=> $stable(level));
    a_r12_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, wr_ptr} < depth) && ({1'b0, rd_ptr} < depth));

endmodule

// File: rtl/sfifo_lane_ram.sv
module sfifo_lane_ram
    import sfifo_pkg::*;
#(
    parameter int BASE_DEPTH = 128,
    parameter int BASE_WIDTH = 36,
    parameter int MODES      = 6,
    localparam int BAW = $clog2(BASE_DEPTH),
    localparam int AW  = BAW + MODES - 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  mode_t                 mode,
    input  logic                  wr_go,
    input  logic [AW-1:0]         wr_ptr,
    input  logic [BASE_WIDTH-1:0] wr_data,
    input  logic                  rd_go,
    input  logic [AW-1:0]         rd_ptr,
    output logic [BASE_WIDTH-1:0] rd_data
);

    logic [BASE_WIDTH-1:0] mem [BASE_DEPTH];

    logic [BASE_WIDTH-1:0] fmask;
    logic [BAW-1:0]        w_idx, r_idx;
    int unsigned           w_off, r_off, width;
    logic [BASE_WIDTH-1:0] w_merge;
    logic [BASE_WIDTH-1:0] rd_d, rd_q;

    // Split each entry pointer into a base-word index and a lane offset.
    always_comb begin
        width = BASE_WIDTH >> mode;
        fmask = ~({BASE_WIDTH{1'b1}} << width);
        w_idx = BAW'(wr_ptr >> mode);
        r_idx = BAW'(rd_ptr >> mode);
        w_off = int'(wr_ptr & AW'((1 << mode) - 1)) * width;
        r_off = int'(rd_ptr & AW'((1 << mode) - 1)) * width;
        w_merge = (mem[w_idx] & ~(fmask << w_off)) | ((wr_data & fmask) << w_off);
        rd_d = rd_q;
        if (rd_go) rd_d = (mem[r_idx] >> r_off) & fmask;
    end

    always_ff @(posedge clk) begin
        if (rst) rd_q <= '0;
        else     rd_q <= rd_d;
    end

    always_ff @(posedge clk) begin
        if (wr_go) mem[w_idx] <= w_merge;
    end

    assign rd_data = rd_q;

    a_r11_data_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_go |=> $stable(rd_data));
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~fmask) == '0);

endmodule

// File: rtl/sfifo_flag_gen.sv
module sfifo_flag_gen #(
    parameter int LW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] depth,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] level_nx,
    input  logic [LW-1:0] ae_thr,
    input  logic [LW-1:0] af_thr,
    output logic          empty,
    output logic          full,
    output logic          aempty,
    output logic          afull
);

    typedef struct packed {
        logic empty;
        logic full;
        logic aempty;
        logic afull;
    } flags_t;

    flags_t fl_q, fl_d;

    always_comb begin
        fl_d.empty  = (level_nx == '0);
        fl_d.full   = (level_nx == depth);
        fl_d.aempty = (level_nx <= ae_thr);
        fl_d.afull  = ({1'b0, level_nx} + {1'b0, af_thr}) >= {1'b0, depth};
    end

    always_ff @(posedge clk) begin
        if (rst) fl_q <= '{empty: 1'b1, full: 1'b0, aempty: 1'b1, afull: 1'b0};
        else     fl_q <= fl_d;
    end

    assign empty  = fl_q.empty;
    assign full   = fl_q.full;
    assign aempty = fl_q.aempty;
    assign afull  = fl_q.afull;

    a_r7_empty_matches_level: assert property (@(posedge clk) disable iff (rst)
        empty == (level == '0));
    a_r7_full_matches_level: assert property (@(posedge clk) disable iff (rst)
        full == (level == depth));
    a_r7_not_both: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));
    a_r8_aempty_when_empty: assert property (@(posedge clk) disable iff (rst)
        empty |-> aempty);

endmodule

// File: rtl/sync_fifo_ctrl.sv
module sync_fifo_ctrl
    import sfifo_pkg::*;
#(
    parameter int BASE_DEPTH = 128,
    parameter int BASE_WIDTH = 36,
    parameter int MODES      = 6,
    localparam int BAW = $clog2(BASE_DEPTH),
    localparam int AW  = BAW + MODES - 1,
    localparam int LW  = AW + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2:0]            cfg_mode,
    input  logic [LW-1:0]         ae_thresh,
    input  logic [LW-1:0]         af_thresh,
    input  logic                  wr_en,
    input  logic [BASE_WIDTH-1:0] wr_data,
    input  logic                  rd_en,
    output logic [BASE_WIDTH-1:0] rd_data,
    output logic                  empty,
    output logic                  full,
    output logic                  almost_empty,
    output logic                  almost_full,
    output logic [LW-1:0]         level
);

    mode_t         mode_q, mode_d;
    logic [LW-1:0] depth;
    logic          wr_go, rd_go;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] level_nx;

    // The aspect mode is taken only under reset, so pointers never see a change.
    always_comb begin
        mode_d = rst ? clamp_mode(mode_t'(cfg_mode), MODES - 1) : mode_q;
        depth  = LW'(BASE_DEPTH) << mode_q;
    end

    always_ff @(posedge clk) begin
        mode_q <= mode_d;
    end

    sfifo_ptr_ctrl #(
        .BASE_DEPTH(BASE_DEPTH),
        .MODES     (MODES)
    ) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .depth   (depth),
        .wr_req  (wr_en),
        .rd_req  (rd_en),
        .wr_go   (wr_go),
        .rd_go   (rd_go),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .level   (level),
        .level_nx(level_nx)
    );

    sfifo_lane_ram #(
        .BASE_DEPTH(BASE_DEPTH),
        .BASE_WIDTH(BASE_WIDTH),
        .MODES     (MODES)
    ) u_ram (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode_q),
        .wr_go  (wr_go),
        .wr_ptr (wr_ptr),
        .wr_data(wr_data),
        .rd_go  (rd_go),
        .rd_ptr (rd_ptr),
        .rd_data(rd_data)
    );

    sfifo_flag_gen #(
        .LW(LW)
    ) u_flags (
        .clk     (clk),
        .rst     (rst),
        .depth   (depth),
        .level   (level),
        .level_nx(level_nx),
        .ae_thr  (ae_thresh),
        .af_thr  (af_thresh),
        .empty   (empty),
        .full    (full),
        .aempty  (almost_empty),
        .afull   (almost_full)
    );

    a_r2_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(depth));

endmodule

// File: tb/tb_sync_fifo_ctrl.sv
`timescale 1ns/1ps
module tb_sync_fifo_ctrl;

    localparam int BD = 128;
    localparam int BW = 36;
    localparam int NM = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic [2:0]    cfg_mode;
    logic [12:0]   ae_thresh, af_thresh;
    logic          wr_en, rd_en;
    logic [BW-1:0] wr_data;
    logic [BW-1:0] rd_data;
    logic          empty, full, almost_empty, almost_full;
    logic [12:0]   level;

    sync_fifo_ctrl #(.BASE_DEPTH(BD), .BASE_WIDTH(BW), .MODES(NM)) dut (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode),
        .ae_thresh(ae_thresh), .af_thresh(af_thresh),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .empty(empty), .full(full), .almost_empty(almost_empty),
        .almost_full(almost_full), .level(level)
    );

    always #10 clk = ~clk;

    int unsigned   nvec = 0, nerr = 0;
    logic [BW-1:0] q[$];
    int            depth;
    logic [BW-1:0] wmask;
    logic [BW-1:0] last_rd;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(input int m);
        int em;
        cfg_mode = 3'(m);
        wr_en = 0; rd_en = 0; wr_data = '0;
        rst = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 empty", 64'(empty), 64'd1);
        chk("R1 full", 64'(full), 64'd0);
        chk("R1 almost_empty", 64'(almost_empty), 64'd1);
        chk("R1 almost_full", 64'(almost_full), 64'd0);
        chk("R1 level", 64'(level), 64'd0);
        chk("R1 rd_data", 64'(rd_data), 64'd0);
        rst = 0;
        em = (m > NM - 1) ? NM - 1 : m;
        depth = BD << em;
        wmask = ~({BW{1'b1}} << (BW >> em));
        q.delete();
        last_rd = '0;
    endtask

    task automatic step(input logic w, input logic [BW-1:0] d, input logic r);
        bit rok, wok;
        logic [BW-1:0] exp_rd;
        wr_en = w; wr_data = d; rd_en = r;
        @(posedge clk);
        rok = r && (q.size() != 0);
        wok = w && (q.size() < depth);
        exp_rd = last_rd;
        if (rok) exp_rd = q.pop_front();
        if (wok) q.push_back(d & wmask);
        @(negedge clk);
        chk("R4 R5 R6 R12 level", 64'(level), 64'(q.size()));
        chk("R7 R10 empty", 64'(empty), 64'(q.size() == 0));
        chk("R7 R10 full", 64'(full), 64'(q.size() == depth));
        chk("R8 R10 almost_empty", 64'(almost_empty), 64'(q.size() <= int'(ae_thresh)));
        chk("R9 R10 almost_full", 64'(almost_full), 64'(q.size() + int'(af_thresh) >= depth));
        if (rok) chk("R3 R2 rd_data", 64'(rd_data), 64'(exp_rd));
        else     chk("R11 R5 rd_data hold", 64'(rd_data), 64'(exp_rd));
        last_rd = exp_rd;
    endtask

    task automatic run_mode(input int m, input int ae, input int af);
        ae_thresh = 13'(ae);
        af_thresh = 13'(af);
        do_reset(m);
        // fill past the top, then drain past the bottom (R4, R5)
        for (int i = 0; i < depth + 3; i++) step(1'b1, {$urandom, $urandom} , 1'b0);
        for (int i = 0; i < depth + 3; i++) step(1'b0, '0, 1'b1);
        // half fill then simultaneous traffic (R6)
        for (int i = 0; i < depth / 2; i++) step(1'b1, {$urandom, $urandom}, 1'b0);
        for (int i = 0; i < 200; i++) step(1'b1, {$urandom, $urandom}, 1'b1);
        // random traffic with moving thresholds (R8, R9, R10, R12)
        for (int i = 0; i < 1500; i++) begin
            if (i % 100 == 0) begin
                ae_thresh = 13'($urandom_range(0, depth));
                af_thresh = 13'($urandom_range(0, depth + 8));
            end
            step(($urandom % 4) != 0 ? 1'b1 : 1'b0, {$urandom, $urandom},
                 ($urandom % 4) < ((i / 300) % 2 == 0 ? 2 : 3) ? 1'b1 : 1'b0);
        end
    endtask

    initial begin
        rst = 1; cfg_mode = '0; ae_thresh = '0; af_thresh = '0;
        wr_en = 0; rd_en = 0; wr_data = '0;
        run_mode(0, 5, 3);
        run_mode(2, 100, 0);
        run_mode(5, 0, 5000);
        run_mode(7, 17, 40);
        // R2: mode change without reset must leave depth alone
        ae_thresh = 13'd10; af_thresh = 13'd2;
        do_reset(0);
        cfg_mode = 3'd5;
        for (int i = 0; i < depth + 4; i++) step(1'b1, {$urandom, $urandom}, 1'b0);
        chk("R2 depth kept without reset", 64'(level), 64'(BD));
        for (int i = 0; i < depth + 2; i++) step(1'b0, '0, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        #(200000 * 20);
        nvec++; nerr++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule